// File: doc/BRIEF.md
# DTMF Tone Command Front End

This block sits between a microcontroller and a dual-tone synthesiser. It accepts tone commands in one of two forms and turns each into a row tone index, a column tone index and an enable for each group. The synthesiser uses these outputs directly. In serial mode the controller shifts 5-bit words in on a data line, least significant bit first. Each bit is taken on a falling edge of a slow sync clock, which is synchronised into the system clock domain. In parallel mode the controller presents a 4-bit key value, and the block decodes that value on every system clock cycle.

An active-low enable powers the function up. After the enable falls, a start-up counter of parameterised length runs on the system clock. No tone reaches the outputs until it has finished. Releasing the enable silences the outputs at once, clears the held command and discards any partly received serial word. Serial codes can select one of sixteen keypad pairs, one of eight single tones, or an explicit silence. Unassigned codes leave the current selection untouched.

Top module: `dtmf_cmd_if`

## Requirements
- R1: A serial word is 5 bits, first bit received = bit 0. Bits are taken on falling edges of `ser_clk` (idle high) while `cs_n` is low and `par_mode` is low. A word takes effect only once its fifth bit is in, and four bits alone leave the outputs unchanged.
- R2: The keypad layout is rows 0..3 = 697/770/852/941 Hz and columns 0..3 = 1209/1336/1477/1633 Hz, with keys laid out as 1 2 3 A / 4 5 6 B / 7 8 9 C / * 0 # D. A serial word with bit 4 = 0 selects a key from its low nibble: 1..9 = keys 1..9, 10 = 0, 11 = *, 12 = #, 13..15 = A..C, 0 = D. Both enables go high.
- R3: Serial words 16..23 (binary 10kkk) select a single tone. Values kkk = 0..3 give row k with only `row_en` high. Values kkk = 4..7 give column k-4 with only `col_en` high.
- R4: Serial word 31 (11111) clears both enables and `tone_on`.
- R5: Serial words 24..30 are ignored, and the previous selection stays on the outputs.
- R6: While `par_mode` is high, `par_key` is decoded with the nibble map of R2, and the result is on the outputs one clock edge later. Serial clock edges have no effect in this mode.
- R7: `cs_n` is first sampled low at clock edge k. The outputs stay off through edge k+WAKE_CYCLES-2 and may carry a tone from edge k+WAKE_CYCLES-1 onward.
- R8: While `cs_n` is high, `row_en`, `col_en` and `tone_on` are low within the same cycle. The held selection is cleared, so nothing is shown after the next start-up.
- R9: Raising `cs_n` discards a partly received serial word. The next full word after re-enable decodes correctly.
- R10: During reset all enables and `tone_on` are low. `tone_on` is high exactly when `row_en` or `col_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip enable |
| par_mode | input | 1 | 1 = parallel key input, 0 = serial words |
| par_key | input | 4 | Parallel key value |
| ser_clk | input | 1 | Serial sync clock, idle high, bit taken on its fall |
| ser_dat | input | 1 | Serial data bit |
| row_idx | output | 2 | Selected row tone (0..3 = 697..941 Hz) |
| col_idx | output | 2 | Selected column tone (0..3 = 1209..1633 Hz) |
| row_en | output | 1 | Row tone enabled |
| col_en | output | 1 | Column tone enabled |
| tone_on | output | 1 | Any tone enabled |

## Verification
A falling serial clock passes two synchroniser flops and one edge-detect flop, and the command register adds one more. A completed word therefore shows on the outputs at the fourth rising edge after its last bit falls. The bench drives that fall and then samples at the falling clock edge five cycles later. A parallel key shows one edge after it is applied, and the bench checks it on the next falling edge. The start-up window is checked on both sides: one cycle before it closes the outputs must be off, and on the closing cycle they must be on. The immediate effect of releasing `cs_n` is sampled one nanosecond after the release, before any rising edge.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  localparam int WORD_BITS = 5;

  typedef struct packed {
    logic       row_en;
    logic       col_en;
    logic [1:0] row;
    logic [1:0] col;
  } tone_sel_t;

  localparam tone_sel_t TONE_OFF = '0;

  // Keypad nibble to row/column pair.
  function automatic tone_sel_t key_to_sel(input logic [3:0] k);
    tone_sel_t  s;
    logic [3:0] idx;
    logic [3:0] q;
    logic [3:0] r;
    s.row_en = 1'b1;
    s.col_en = 1'b1;
    idx = k - 4'd1;
    q   = idx / 4'd3;
    r   = idx % 4'd3;
    if (k == 4'd0) begin
      s.row = 2'd3; s.col = 2'd3;
    end else if (k <= 4'd9) begin
      s.row = q[1:0]; s.col = r[1:0];
    end else if (k == 4'd10) begin
      s.row = 2'd3; s.col = 2'd1;
    end else if (k == 4'd11) begin
      s.row = 2'd3; s.col = 2'd0;
    end else if (k == 4'd12) begin
      s.row = 2'd3; s.col = 2'd2;
    end else begin
      idx = k - 4'd13;
      s.row = idx[1:0]; s.col = 2'd3;
    end
    return s;
  endfunction

  // Serial word carries an assigned meaning.
  function automatic logic ser_known(input logic [WORD_BITS-1:0] w);
    return !w[4] || !w[3] || (w == 5'h1F);
  endfunction

  // Serial word to selection (only meaningful when ser_known).
  function automatic tone_sel_t ser_to_sel(input logic [WORD_BITS-1:0] w);
    tone_sel_t s;
    s = TONE_OFF;
    if (!w[4]) begin
      s = key_to_sel(w[3:0]);
    end else if (!w[3]) begin
      if (!w[2]) begin
        s.row_en = 1'b1; s.row = w[1:0];
      end else begin
        s.col_en = 1'b1; s.col = w[1:0];
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/dtmf_sync.sv
module dtmf_sync #(
  parameter int       STAGES    = 2,
  parameter int       WIDTH     = 1,
  parameter bit       RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= {WIDTH{RESET_VAL}};
      else if (i == 0) chain[i] <= d;
      else chain[i] <= chain[(i == 0) ? 0 : i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dtmf_ser_rx.sv
module dtmf_ser_rx
  import dtmf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 ser_clk,
  input  logic                 ser_dat,
  output logic                 word_valid,
  output logic [WORD_BITS-1:0] word,
  output logic                 fall_evt
);
  localparam int                CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(WORD_BITS - 1);

  logic [1:0]       sync_q;
  logic             sclk_s, sdat_s, sclk_q;
  logic [CNT_W-1:0] bit_cnt;

  dtmf_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ser_clk, ser_dat}), .q(sync_q)
  );
  assign sclk_s   = sync_q[1];
  assign sdat_s   = sync_q[0];
  assign fall_evt = sclk_q & ~sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b1;
      bit_cnt    <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      sclk_q     <= sclk_s;
      word_valid <= 1'b0;
      if (!enable) begin
        bit_cnt <= '0;
      end else if (fall_evt) begin
        word <= {sdat_s, word[WORD_BITS-1:1]};
        if (bit_cnt == LAST) begin
          bit_cnt    <= '0;
          word_valid <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST);
  p_valid_after_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(fall_evt && enable));
  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (bit_cnt == '0) && !word_valid);
endmodule

// File: rtl/dtmf_wake_timer.sv
module dtmf_wake_timer #(
  parameter int WAKE_CYCLES = 24000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic ready
);
  localparam int             CW   = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0]  DONE = CW'(WAKE_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (cs_n)         cnt <= '0;
    else if (cnt != DONE)  cnt <= cnt + 1'b1;
  end

  assign ready = (cnt == DONE);

  p_ready_needs_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $past(!cs_n));
  p_cs_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !ready);
endmodule

// File: rtl/dtmf_cmd_if.sv
module dtmf_cmd_if
  import dtmf_pkg::*;
#(
  parameter int WAKE_CYCLES = 24000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       par_mode,
  input  logic [3:0] par_key,
  input  logic       ser_clk,
  input  logic       ser_dat,
  output logic [1:0] row_idx,
  output logic [1:0] col_idx,
  output logic       row_en,
  output logic       col_en,
  output logic       tone_on
);
  logic                 rx_enable, word_valid, fall_evt, ready, out_gate;
  logic [WORD_BITS-1:0] word;
  logic                 word_known;
  tone_sel_t            cmd;

  assign rx_enable = ~cs_n & ~par_mode;

  dtmf_ser_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .enable(rx_enable),
    .ser_clk(ser_clk), .ser_dat(ser_dat),
    .word_valid(word_valid), .word(word), .fall_evt(fall_evt)
  );

  dtmf_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ready(ready)
  );

  assign word_known = ser_known(word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cmd <= TONE_OFF;
    else if (cs_n)                    cmd <= TONE_OFF;
    else if (par_mode)                cmd <= key_to_sel(par_key);
    else if (word_valid && word_known) cmd <= ser_to_sel(word);
  end

  assign out_gate = ready & ~cs_n;
  assign row_idx  = cmd.row;
  assign col_idx  = cmd.col;
  assign row_en   = cmd.row_en & out_gate;
  assign col_en   = cmd.col_en & out_gate;
  assign tone_on  = row_en | col_en;

  p_out_needs_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_en || col_en) |-> !cs_n);
  p_cmd_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cmd == TONE_OFF));
  p_unused_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_known && !cs_n && !par_mode) |=> $stable(cmd));
  p_off_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word == 5'h1F && !cs_n && !par_mode) |=> !cmd.row_en && !cmd.col_en);
  p_par_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && par_mode) |=> (cmd == key_to_sel($past(par_key))));
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> !tone_on);
endmodule

// File: tb/tb_dtmf_cmd_if.sv
module tb_dtmf_cmd_if;
  localparam int    WAKE   = 16;
  localparam string KEYPAD = "123A456B789C*0#D";

  logic       clk = 1'b0;
  logic       rst_n, cs_n, par_mode, ser_clk, ser_dat;
  logic [3:0] par_key;
  logic [1:0] row_idx, col_idx;
  logic       row_en, col_en, tone_on;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dtmf_cmd_if #(.WAKE_CYCLES(WAKE), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .par_mode(par_mode), .par_key(par_key),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .row_idx(row_idx), .col_idx(col_idx),
    .row_en(row_en), .col_en(col_en), .tone_on(tone_on)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_tone(input string req, input bit re, input bit ce,
                            input int r, input int c);
    check(req, "row_en", int'(row_en), int'(re));
    check(req, "col_en", int'(col_en), int'(ce));
    check(req, "tone_on", int'(tone_on), int'(re | ce));
    if (re) check(req, "row_idx", int'(row_idx), r);
    if (ce) check(req, "col_idx", int'(col_idx), c);
  endtask

  function automatic logic [3:0] key_code(input byte k);
    if (k >= "1" && k <= "9") return 4'(k - "0");
    if (k == "0") return 4'd10;
    if (k == "*") return 4'd11;
    if (k == "#") return 4'd12;
    if (k >= "A" && k <= "C") return 4'(k - "A" + 13);
    return 4'd0;
  endfunction

  task automatic send_bit(input logic b);
    ser_dat = b; ser_clk = 1'b1;
    step(3);
    ser_clk = 1'b0;
    step(3);
    ser_clk = 1'b1;
  endtask

  task automatic send_bits(input logic [4:0] w, input int n);
    for (int i = 0; i < n; i++) send_bit(w[i]);
    step(2);
  endtask

  task automatic key_expect(input byte k, input string req);
    for (int i = 0; i < 16; i++)
      if (KEYPAD[i] == k) check_tone(req, 1'b1, 1'b1, i / 4, i % 4);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cs_n = 1'b1; par_mode = 1'b0; par_key = 4'd0;
    ser_clk = 1'b1; ser_dat = 1'b1;
    step(3);
    check_tone("R10", 1'b0, 1'b0, 0, 0);
    rst_n = 1'b1;
    step(2);
  endtask

  task automatic t_wake;
    par_mode = 1'b1; par_key = key_code("5"); cs_n = 1'b0;
    step(WAKE - 1);
    check_tone("R7 before", 1'b0, 1'b0, 0, 0);
    step(1);
    key_expect("5", "R7 after");
  endtask

  task automatic t_parallel;
    for (int i = 0; i < 16; i++) begin
      par_key = key_code(KEYPAD[i]);
      step(1);
      key_expect(KEYPAD[i], "R6 par");
    end
    par_key = key_code("#");
    step(1);
    send_bits(5'h1F, 5);
    key_expect("#", "R6 serial ignored");
    par_mode = 1'b0;
    step(2);
  endtask

  task automatic t_ser_keys;
    for (int i = 0; i < 16; i++) begin
      send_bits({1'b0, key_code(KEYPAD[i])}, 5);
      key_expect(KEYPAD[i], "R2 serial key");
    end
  endtask

  task automatic t_ser_single;
    for (int k = 0; k < 8; k++) begin
      send_bits(5'(16 + k), 5);
      if (k < 4) check_tone("R3 row", 1'b1, 1'b0, k, 0);
      else       check_tone("R3 col", 1'b0, 1'b1, 0, k - 4);
    end
  endtask

  task automatic t_off_unused;
    send_bits({1'b0, key_code("5")}, 5);
    send_bits(5'h1F, 5);
    check_tone("R4 off", 1'b0, 1'b0, 0, 0);
    send_bits({1'b0, key_code("7")}, 5);
    for (int w = 24; w <= 30; w++) begin
      send_bits(5'(w), 5);
      key_expect("7", "R5 unused");
    end
  endtask

  task automatic t_partial;
    logic [4:0] w8;
    w8 = {1'b0, key_code("8")};
    send_bits({1'b0, key_code("2")}, 5);
    send_bits(w8, 4);
    key_expect("2", "R1 four bits");
    send_bit(w8[4]);
    step(2);
    key_expect("8", "R1 fifth bit");
  endtask

  task automatic t_cs_release;
    cs_n = 1'b1;
    #1;
    check_tone("R8 immediate", 1'b0, 1'b0, 0, 0);
    step(2);
    cs_n = 1'b0;
    send_bits(5'h1F, 3);
    cs_n = 1'b1;
    step(2);
    cs_n = 1'b0;
    step(WAKE + 1);
    check_tone("R8 cleared", 1'b0, 1'b0, 0, 0);
    send_bits({1'b0, key_code("9")}, 5);
    key_expect("9", "R9 realign");
  endtask

  initial begin
    t_reset();
    t_wake();
    t_parallel();
    t_ser_keys();
    t_ser_single();
    t_off_unused();
    t_partial();
    t_cs_release();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule